// File: doc/BRIEF.md
# Card Data FIFO Transfer Engine

This block moves the data phase of a card transfer between a word-wide FIFO on the host side and a byte-wide card data port. A one-cycle start strobe sets the direction and a byte length. In the receive direction, card bytes are packed into words with the least significant byte first. In the transmit direction, words taken from the FIFO are split into bytes, again with the low byte first. The host side pushes and pops whole words.

Two counters run at the same time. The byte counter tracks card-side traffic. The word counter tracks host-side accesses, and it is loaded with the number of words the byte length needs. The engine stays busy until both counters reach zero. This means a receive transfer is only finished once the host has drained every word. Status flags describe FIFO occupancy, but only for the active direction. Data-end and block-end markers and sticky error bits report the outcome of the transfer.

Top module: `card_fifo_xfer`

## Requirements
- R1: A cycle with `start` high flushes the FIFO and clears the data-end, block-end and error bits. It loads the byte counter with `start_len` and the word counter with ceil(`start_len`/4). The direction is taken from `start_dir_rx` (1 = receive, 0 = transmit). A length of zero leaves `busy` low and sets data-end at once.
- R2: In receive, byte k of a word (k = 0..3) lands in bits 8k+7..8k. The word enters the FIFO once its fourth byte is accepted.
- R3: In receive, when the byte counter reaches zero, a partly filled last word enters the FIFO. Its unused upper bytes are zero.
- R4: In transmit, each FIFO word leaves on `tx_byte` low byte first, as four consecutive bytes (fewer for the last word of a length that is not a multiple of 4).
- R5: `rx_ready` is high only in receive, with bytes remaining and fewer than 16 words in the FIFO. `tx_valid` is high only in transmit, with bytes remaining and either a word in the FIFO or bytes left in the current word.
- R6: `data_end` and `block_end` go high in the cycle after the last card byte moves. They stay high until the next start.
- R7: `busy` falls only when both the byte counter and the word counter are zero. A receive transfer whose bytes are all in stays busy until the host has popped every word.
- R8: `tx_stat` and `rx_stat` are 5-bit vectors: bit0 active, bit1 empty (0 words), bit2 data available (non-zero), bit3 full (16 words), bit4 half. For `tx_stat`, half means 8 words or fewer; for `rx_stat`, it means 8 or more. The vector of the direction not in use, and both vectors when idle, read zero.
- R9: A host push is taken only in transmit, and a host pop only in receive, and either only while the word counter is non-zero. Any other access is ignored: it has no effect on the FIFO, the counters or the error bits. `h_rdata` reads zero when no pop can be taken.
- R10: A push into a full FIFO or a pop from an empty FIFO changes neither the FIFO nor the word counter. It sets the sticky `ovf_err` or `unf_err` bit respectively.
- R11: At most one card byte moves per clock. A host access and a card-side byte move may happen in the same cycle.
- R12: After reset, `busy`, both status vectors, `rx_ready`, `tx_valid`, `h_rdata`, `data_end`, `block_end` and both error bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer start strobe |
| start_dir_rx | input | 1 | Direction at start: 1 receive, 0 transmit |
| start_len | input | LEN_W | Byte length at start |
| h_push | input | 1 | Host word push |
| h_wdata | input | WORD_W | Host push data |
| h_pop | input | 1 | Host word pop |
| h_rdata | output | WORD_W | Word at the FIFO head, zero when no pop can be taken |
| rx_valid | input | 1 | Card has a receive byte ready |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Engine accepts a receive byte |
| tx_valid | output | 1 | Engine offers a transmit byte |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Card accepts the transmit byte |
| busy | output | 1 | Transfer in progress |
| tx_stat | output | 5 | Transmit FIFO flags |
| rx_stat | output | 5 | Receive FIFO flags |
| data_end | output | 1 | Byte counter reached zero |
| block_end | output | 1 | Block completion marker |
| ovf_err | output | 1 | Sticky push-into-full error |
| unf_err | output | 1 | Sticky pop-from-empty error |

## Verification
The bench targets lengths that are not multiples of four in both directions. A design that misplaced the partial word would leave garbage in the upper bytes, or would never push the word. It fills the FIFO to 16 words with a receive length longer than the FIFO: a wrong full guard would overwrite the head word or deadlock the card port. It checks that `busy` holds after the last receive byte until the final pop, which catches an engine that idles on the byte counter alone. Finally it pushes into a full FIFO, pops from an empty one, and makes accesses in the wrong direction. These cases expose a design that corrupts the occupancy count or spends a word count on a rejected access.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } cfx_dir_e;

    // bit0 active, bit1 empty, bit2 data available, bit3 full, bit4 half
    typedef struct packed {
        logic half;
        logic full;
        logic avail;
        logic empty;
        logic active;
    } cfx_stat_t;

    localparam int STAT_W = $bits(cfx_stat_t);

endpackage

// File: rtl/cfx_wordfifo.sv
module cfx_wordfifo #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop_req,
    output logic [WORD_W-1:0] head,
    output logic [OCC_W-1:0]  occ,
    output logic              push_rej,
    output logic              pop_rej
);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_slot;
    logic [OCC_W-1:0]  occ_q;
    logic              push_ok;
    logic              pop_ok;

    // DEPTH is a power of two, so the slot wraps naturally
    assign wr_slot  = rd_ptr + PTR_W'(occ_q);
    assign push_ok  = push_req && (occ_q != FULL_OCC);
    assign pop_ok   = pop_req && (occ_q != '0);
    assign push_rej = push_req && !push_ok;
    assign pop_rej  = pop_req && !pop_ok;
    assign head     = mem[rd_ptr];
    assign occ      = occ_q;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_slot] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ_q <= FULL_OCC); // R10
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (push_req && occ_q == FULL_OCC && !pop_req && !flush) |=> $stable(occ_q)); // R10

endmodule

// File: rtl/cfx_bytepath.sv
module cfx_bytepath
    import cfx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  cfx_dir_e          dir,
    input  logic              run,
    input  logic              last,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] head,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              byte_fire,
    output logic              push_req,
    output logic [WORD_W-1:0] push_word,
    output logic              pop_req
);
    localparam int BPW  = WORD_W / 8;
    localparam int NB_W = $clog2(BPW);
    localparam int PD_W = $clog2(BPW + 1);
    localparam logic [NB_W-1:0] LAST_LANE = NB_W'(BPW - 1);

    logic [WORD_W-1:0] acc;
    logic [NB_W-1:0]   lane;
    logic [WORD_W-1:0] shreg;
    logic [PD_W-1:0]   pend;
    logic              rx_fire;
    logic              tx_fire;
    logic [WORD_W-1:0] merged;

    // receive: pack bytes little-endian
    assign rx_ready  = run && (dir == DIR_RX) && !fifo_full;
    assign rx_fire   = rx_ready && rx_valid;
    assign merged    = acc | ({{(WORD_W-8){1'b0}}, rx_byte} << {lane, 3'b000});
    assign push_req  = rx_fire && ((lane == LAST_LANE) || last);
    assign push_word = merged;

    // transmit: unpack words low byte first
    assign tx_valid  = run && (dir == DIR_TX) && ((|pend) || !fifo_empty);
    assign tx_byte   = (|pend) ? shreg[7:0] : head[7:0];
    assign tx_fire   = tx_valid && tx_ready;
    assign pop_req   = tx_fire && !(|pend);

    assign byte_fire = rx_fire || tx_fire;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc   <= '0;
            lane  <= '0;
            shreg <= '0;
            pend  <= '0;
        end else begin
            if (rx_fire) begin
                if (push_req) begin
                    acc  <= '0;
                    lane <= '0;
                end else begin
                    acc  <= merged;
                    lane <= lane + 1'b1;
                end
            end
            if (tx_fire) begin
                if (|pend) begin
                    shreg <= shreg >> 8;
                    pend  <= pend - 1'b1;
                end else begin
                    shreg <= head >> 8;
                    pend  <= PD_W'(BPW - 1);
                end
            end
        end
    end

endmodule

// File: rtl/cfx_flags.sv
module cfx_flags
    import cfx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             active,
    input  cfx_dir_e         dir,
    input  logic [OCC_W-1:0] occ,
    output cfx_stat_t        tx_stat,
    output cfx_stat_t        rx_stat
);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] HALF_OCC = OCC_W'(DEPTH / 2);

    cfx_stat_t base;

    always_comb begin
        base        = '0;
        base.active = active;
        base.empty  = active && (occ == '0);
        base.avail  = active && (occ != '0);
        base.full   = active && (occ == FULL_OCC);

        tx_stat      = base;
        tx_stat.half = active && (occ <= HALF_OCC);
        rx_stat      = base;
        rx_stat.half = active && (occ >= HALF_OCC);

        if (dir == DIR_RX) begin
            tx_stat = '0;
        end else begin
            rx_stat = '0;
        end
    end

endmodule

// File: rtl/card_fifo_xfer.sv
module card_fifo_xfer
    import cfx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_dir_rx,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              h_push,
    input  logic [WORD_W-1:0] h_wdata,
    input  logic              h_pop,
    output logic [WORD_W-1:0] h_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready,
    output logic              busy,
    output logic [4:0]        tx_stat,
    output logic [4:0]        rx_stat,
    output logic              data_end,
    output logic              block_end,
    output logic              ovf_err,
    output logic              unf_err
);
    localparam int BPW   = WORD_W / 8;
    localparam int SH_W  = $clog2(BPW);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    cfx_dir_e          dir_q;
    logic [LEN_W-1:0]  bc_q, bc_n;
    logic [LEN_W-1:0]  wc_q, wc_n;
    logic [LEN_W:0]    len_round;
    logic [LEN_W-1:0]  wc_load;
    logic              busy_q, busy_n;
    logic              dend_q, bend_q, ovf_q, unf_q;

    logic              run, last, wc_nz;
    logic              byte_fire;
    logic              pk_push, tx_pop;
    logic [WORD_W-1:0] pk_word;
    logic              host_push_take, host_pop_take;
    logic              f_push, f_pop;
    logic [WORD_W-1:0] f_wdata;
    logic [WORD_W-1:0] f_head;
    logic [OCC_W-1:0]  f_occ;
    logic              f_push_rej, f_pop_rej;
    logic              wc_step;
    cfx_stat_t         tx_s, rx_s;

    assign run   = busy_q && (bc_q != '0);
    assign last  = (bc_q == LEN_W'(1));
    assign wc_nz = (wc_q != '0);

    // host accesses count only in their own direction and while words remain
    assign host_push_take = h_push && wc_nz && (dir_q == DIR_TX);
    assign host_pop_take  = h_pop && wc_nz && (dir_q == DIR_RX);

    assign f_push  = (dir_q == DIR_RX) ? pk_push : host_push_take;
    assign f_wdata = (dir_q == DIR_RX) ? pk_word : h_wdata;
    assign f_pop   = (dir_q == DIR_RX) ? host_pop_take : tx_pop;

    assign wc_step = (host_push_take && !f_push_rej) || (host_pop_take && !f_pop_rej);

    assign h_rdata = (wc_nz && (dir_q == DIR_RX) && (f_occ != '0)) ? f_head : '0;

    cfx_wordfifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (start),
        .push_req  (f_push),
        .push_data (f_wdata),
        .pop_req   (f_pop),
        .head      (f_head),
        .occ       (f_occ),
        .push_rej  (f_push_rej),
        .pop_rej   (f_pop_rej)
    );

    cfx_bytepath #(.WORD_W(WORD_W)) u_bytes (
        .clk        (clk),
        .rst        (rst),
        .clr        (start),
        .dir        (dir_q),
        .run        (run),
        .last       (last),
        .fifo_full  (f_occ == FULL_OCC),
        .fifo_empty (f_occ == '0),
        .head       (f_head),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rx_ready   (rx_ready),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .byte_fire  (byte_fire),
        .push_req   (pk_push),
        .push_word  (pk_word),
        .pop_req    (tx_pop)
    );

    cfx_flags #(.DEPTH(DEPTH)) u_flags (
        .active  (busy_q),
        .dir     (dir_q),
        .occ     (f_occ),
        .tx_stat (tx_s),
        .rx_stat (rx_s)
    );

    always_comb begin
        len_round = {1'b0, start_len} + (LEN_W+1)'(BPW - 1);
        wc_load   = LEN_W'(len_round >> SH_W);
        if (start) begin
            bc_n   = start_len;
            wc_n   = wc_load;
            busy_n = (start_len != '0);
        end else begin
            bc_n   = byte_fire ? (bc_q - 1'b1) : bc_q;
            wc_n   = wc_step ? (wc_q - 1'b1) : wc_q;
            busy_n = busy_q && ((bc_n != '0) || (wc_n != '0));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_TX;
            bc_q   <= '0;
            wc_q   <= '0;
            busy_q <= 1'b0;
            dend_q <= 1'b0;
            bend_q <= 1'b0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            bc_q   <= bc_n;
            wc_q   <= wc_n;
            busy_q <= busy_n;
            if (start) begin
                dir_q  <= start_dir_rx ? DIR_RX : DIR_TX;
                dend_q <= (start_len == '0);
                bend_q <= (start_len == '0);
                ovf_q  <= 1'b0;
                unf_q  <= 1'b0;
            end else begin
                if (byte_fire && last) begin
                    dend_q <= 1'b1;
                    bend_q <= 1'b1;
                end
                ovf_q <= ovf_q || f_push_rej;
                unf_q <= unf_q || f_pop_rej;
            end
        end
    end

    assign busy      = busy_q;
    assign tx_stat   = tx_s;
    assign rx_stat   = rx_s;
    assign data_end  = dend_q;
    assign block_end = bend_q;
    assign ovf_err   = ovf_q;
    assign unf_err   = unf_q;

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && $past(busy_q) && !$past(start)) |-> (bc_q == '0 && wc_q == '0)); // R7
    AST_DATA_END_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bc_q == '0) |-> (dend_q && bend_q)); // R6
    AST_ONE_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        !start |=> (bc_q == $past(bc_q)) || (bc_q == $past(bc_q) - 1'b1)); // R11
    AST_RX_READY_ROOM: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> (rx_s.active && !rx_s.full)); // R5
    AST_TX_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_s.active && rx_s == '0)); // R8

endmodule

// File: tb/card_fifo_xfer_test.sv
module card_fifo_xfer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCASE = 9;
    localparam int CASE_DIR [NCASE] = '{1, 1, 1, 1, 1, 0, 0, 0, 0};
    localparam int CASE_LEN [NCASE] = '{1, 3, 4, 7, 64, 1, 5, 8, 62};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        start_dir_rx = 1'b0;
    logic [15:0] start_len = '0;
    logic        h_push = 1'b0;
    logic [31:0] h_wdata = '0;
    logic        h_pop = 1'b0;
    logic [31:0] h_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;
    logic        busy;
    logic [4:0]  tx_stat, rx_stat;
    logic        data_end, block_end, ovf_err, unf_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_fifo_xfer uut (
        .clk(clk), .rst(rst), .start(start), .start_dir_rx(start_dir_rx),
        .start_len(start_len), .h_push(h_push), .h_wdata(h_wdata),
        .h_pop(h_pop), .h_rdata(h_rdata), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_ready(tx_ready), .busy(busy),
        .tx_stat(tx_stat), .rx_stat(rx_stat), .data_end(data_end),
        .block_end(block_end), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    function automatic logic [7:0] bval(int seed, int k);
        return 8'((seed * 37 + k * 13 + 5) & 255);
    endfunction

    function automatic logic [31:0] wexp(int seed, int i, int len);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++) begin
            if (4 * i + j < len) w |= 32'(bval(seed, 4 * i + j)) << (8 * j);
        end
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic do_start(bit dir, int len);
        start = 1'b1;
        start_dir_rx = dir;
        start_len = 16'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic rx_feed(int seed, int k0, int n);
        int sent = 0;
        while (sent < n) begin
            if (rx_ready) begin
                rx_valid = 1'b1;
                rx_byte = bval(seed, k0 + sent);
                sent++;
            end else begin
                rx_valid = 1'b0;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    task automatic host_pop(string req, logic [31:0] exp);
        chk(req, h_rdata, exp);
        h_pop = 1'b1;
        @(negedge clk);
        h_pop = 1'b0;
    endtask

    task automatic host_push(logic [31:0] w);
        h_push = 1'b1;
        h_wdata = w;
        @(negedge clk);
        h_push = 1'b0;
    endtask

    task automatic tx_collect(string req, int seed, int k0, int n);
        int got = 0;
        while (got < n) begin
            if (tx_valid) begin
                chk(req, 32'(tx_byte), 32'(bval(seed, k0 + got)));
                tx_ready = 1'b1;
                got++;
            end else begin
                tx_ready = 1'b0;
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", 32'(busy), 0);
        chk("R12 stats", {22'd0, tx_stat, rx_stat}, 0);
        chk("R12 handshakes", {30'd0, rx_ready, tx_valid}, 0);
        chk("R12 rdata", h_rdata, 0);
        chk("R12 markers", {28'd0, data_end, block_end, ovf_err, unf_err}, 0);

        // table walk: R2 R3 (receive) and R4 (transmit), R6 R7 on each
        for (int c = 0; c < NCASE; c++) begin
            int len = CASE_LEN[c];
            int nw = (len + 3) / 4;
            int seed = c + 1;
            do_start(CASE_DIR[c] != 0, len);
            if (CASE_DIR[c] != 0) begin
                rx_feed(seed, 0, len);
                chk("R7 busy while words remain", 32'(busy), 1);
                chk("R6 data_end rx", {30'd0, data_end, block_end}, 3);
                for (int i = 0; i < nw; i++) begin
                    host_pop((i == nw - 1 && len % 4 != 0) ? "R3 partial word" : "R2 packed word",
                             wexp(seed, i, len));
                end
                chk("R7 idle after last pop", 32'(busy), 0);
            end else begin
                for (int i = 0; i < nw; i++) host_push(wexp(seed, i, len));
                tx_collect("R4 byte order", seed, 0, len);
                chk("R7 idle after tx", 32'(busy), 0);
                chk("R6 data_end tx", {30'd0, data_end, block_end}, 3);
            end
        end

        // R1 zero length
        do_start(0, 0);
        chk("R1 zero length busy", 32'(busy), 0);
        chk("R1 zero length data_end", 32'(data_end), 1);

        // R8 transmit flags, R9 word counter exhausted
        do_start(0, 64);
        chk("R8 tx empty", 32'(tx_stat), 32'b10011);
        chk("R8 rx masked", 32'(rx_stat), 0);
        for (int i = 0; i < 8; i++) host_push(wexp(20, i, 64));
        chk("R8 tx half", 32'(tx_stat), 32'b10101);
        for (int i = 8; i < 16; i++) host_push(wexp(20, i, 64));
        chk("R8 tx full", 32'(tx_stat), 32'b01101);
        host_push(32'hdeadbeef);
        chk("R9 push past word count ignored", {31'd0, ovf_err}, 0);
        chk("R9 fifo unchanged", 32'(tx_stat), 32'b01101);
        tx_collect("R4 full fifo drain", 20, 0, 64);
        chk("R7 tx done", 32'(busy), 0);

        // R5 receive backpressure at 16 words, R8 receive flags
        do_start(1, 68);
        rx_feed(30, 0, 64);
        repeat (2) @(negedge clk);
        chk("R5 rx_ready low when full", 32'(rx_ready), 0);
        chk("R8 rx full", 32'(rx_stat), 32'b11101);
        chk("R8 tx masked", 32'(tx_stat), 0);
        host_pop("R5 head word", wexp(30, 0, 68));
        chk("R5 rx_ready after pop", 32'(rx_ready), 1);
        rx_feed(30, 64, 4);
        for (int i = 1; i < 17; i++) host_pop("R5 remaining words", wexp(30, i, 68));
        chk("R7 rx done", 32'(busy), 0);

        // R10 overflow, then recovery
        do_start(0, 68);
        for (int i = 0; i < 16; i++) host_push(wexp(40, i, 68));
        host_push(wexp(40, 16, 68));
        chk("R10 ovf_err set", 32'(ovf_err), 1);
        chk("R10 fifo still full", 32'(tx_stat), 32'b01101);
        tx_collect("R10 bytes before retry", 40, 0, 4);
        host_push(wexp(40, 16, 68));
        tx_collect("R10 bytes after retry", 40, 4, 64);
        chk("R10 word not lost", 32'(busy), 0);
        chk("R10 ovf_err sticky", 32'(ovf_err), 1);

        // R10 underflow, R9 wrong-direction push, R1 clears errors
        do_start(1, 8);
        chk("R1 start clears ovf_err", 32'(ovf_err), 0);
        host_push(32'h12345678);
        chk("R9 push in rx ignored", 32'(rx_stat), 32'b00011);
        chk("R9 no error from ignored push", 32'(ovf_err), 0);
        host_pop("R10 rdata zero on empty", 0);
        chk("R10 unf_err set", 32'(unf_err), 1);
        chk("R10 fifo still empty", 32'(rx_stat), 32'b00011);
        rx_feed(50, 0, 8);
        host_pop("R10 word count kept", wexp(50, 0, 8));
        host_pop("R10 word count kept", wexp(50, 1, 8));
        chk("R10 rx idle", 32'(busy), 0);
        host_pop("R9 pop when idle reads zero", 0);
        chk("R9 idle pop no error change", 32'(unf_err), 1);

        // R11 host push and card byte in one cycle
        do_start(0, 8);
        host_push(wexp(60, 0, 8));
        chk("R11 first byte offered", {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, bval(60, 0)});
        tx_ready = 1'b1;
        h_push = 1'b1;
        h_wdata = wexp(60, 1, 8);
        @(negedge clk);
        tx_ready = 1'b0;
        h_push = 1'b0;
        chk("R11 one word after swap", 32'(tx_stat), 32'b10101);
        tx_collect("R11 byte stream", 60, 1, 7);
        chk("R11 done", {30'd0, busy, data_end}, 1);

        report();
    end
endmodule